// File: doc/BRIEF.md
# Stack and Interrupt Sequencer

This block handles every control-flow event of an 8-bit processor that touches the hardware stack or a fixed vector. These events are power-on restart, the non-maskable and maskable interrupt entries, the software break, subroutine call and return, interrupt return, and pushing or pulling the status byte. The stack always lives in memory page one, and the block owns the 8-bit stack pointer. It drives a byte-wide memory port with one access per cycle. At the end of each sequence it presents the resulting program counter, status byte and stack pointer to the rest of the core.

The instruction sequencer sends a one-cycle command with the current PC, a call target and the current status byte. The block then works through its memory accesses and raises `done` for one cycle. With `done` it reports the processor cycle cost of the event and whether an instruction may issue. An issue-boundary command named STEP serves three purposes: it consumes a pending stall, it starts interrupt entry, or it simply grants issue. The block holds one pending-interrupt slot, which is cleared when the interrupt is taken. It also holds a stall counter that adds up requests from other agents, such as a DMA engine.

Top module: `stack_irq_seq`

## Requirements
- R1: A push writes address 0x0100 + SP and then decrements SP. A pull first increments SP and then reads 0x0100 + SP. SP wraps modulo 256, so a pull with SP=0xFF reads 0x0100 and leaves SP=0x00, and a push with SP=0x00 writes 0x0100 and leaves SP=0xFF. Reads and writes are never driven in the same cycle.
- R2: After `rst_n`, SP=0xFD and the status is 0x24. The RESET command (cmd_op=2) reads 0xFFFC and then 0xFFFD, and loads the PC little-endian from them. It sets SP=0xFD and status=0x24, and reports 7 cycles.
- R3: Interrupt entry writes, in order, the PC high byte, the PC low byte, and the status with bit 4 (break) forced to 1. It then reads the vector little-endian. The resulting status equals the input status with bit 2 (interrupt disable) set, and the entry reports 7 cycles. A non-maskable request uses vector 0xFFFA/0xFFFB.
- R4: A maskable request and the BRK command (cmd_op=3) use the same push sequence, with vector 0xFFFE/0xFFFF.
- R5: A single pending-interrupt slot is serviced by STEP (cmd_op=1) and cleared when taken. The next STEP sees no interrupt and reports 0 cycles with issue allowed.
- R6: When both requests arrive together, the non-maskable one is taken. Because the slot holds one entry, the maskable request is lost.
- R7: A pending maskable request is not taken while the status input bit 2 is 1. It stays pending and is taken at the first STEP where bit 2 is 0.
- R8: Stall requests add up. While the counter is nonzero, each STEP decrements it, reports 1 cycle, denies issue and makes no memory access. A stall is consumed before a pending interrupt is serviced.
- R9: PHP (cmd_op=7) pushes the status with bit 4 set and reports 3 cycles. PLP (cmd_op=8) pulls a byte, loads status = (byte AND 0xEF) OR 0x20, and reports 4 cycles.
- R10: RTI (cmd_op=6) pulls the status first (masked as in R9), then the PC low byte, then the PC high byte, and reports 6 cycles.
- R11: JSR (cmd_op=4) pushes pc_in−1 high byte first and loads the PC from target_in. RTS (cmd_op=5) pulls the low byte, then the high byte, and adds 1. Both report 6 cycles.
- R12: `done` is a one-cycle pulse. It appears N+1 clock edges after the edge that accepts the command, where N is the number of memory accesses. `busy` is high from acceptance until `done`, and a command presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Command code: 1 STEP, 2 RESET, 3 BRK, 4 JSR, 5 RTS, 6 RTI, 7 PHP, 8 PLP |
| pc_in | input | 16 | Current PC (PC after the instruction for JSR and BRK) |
| target_in | input | 16 | Call target for JSR |
| status_in | input | 8 | Current status byte (bit0 C, bit1 Z, bit2 I, bit3 D, bit4 B, bit5 U, bit6 V, bit7 N) |
| nmi_req | input | 1 | Non-maskable interrupt request strobe |
| irq_req | input | 1 | Maskable interrupt request strobe |
| stall_add_valid | input | 1 | Adds stall_add_amt to the stall counter |
| stall_add_amt | input | ADD_W (8) | Stall cycles to add |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; mem_rdata is expected in the same cycle |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| issue_ok | output | 1 | With done after STEP: an instruction may issue |
| cycles_out | output | CYC_W (4) | Processor cycle cost of the finished sequence |
| pc_out | output | 16 | Resulting PC |
| status_out | output | 8 | Resulting status byte |
| sp_out | output | 8 | Stack pointer |

## Verification
The block puts one memory access on the port in each cycle after the accepting edge. Its results (PC, status, SP and cycle cost) become valid together with `done`, N+1 edges after acceptance. Every scenario task drives its command on a falling edge and counts falling edges until `done`. It compares that count with N+1 before sampling any result, so a missing or extra state shows up as a latency error. The bench records memory traffic at the rising edges in order, and each access is checked against its expected address and data. Interrupt and stall strobes are applied one full cycle before the STEP that consumes them.

// File: rtl/sis_pkg.sv
package sis_pkg;

    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_STEP  = 4'd1,
        OP_RESET = 4'd2,
        OP_BRK   = 4'd3,
        OP_JSR   = 4'd4,
        OP_RTS   = 4'd5,
        OP_RTI   = 4'd6,
        OP_PHP   = 4'd7,
        OP_PLP   = 4'd8
    } sis_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_HI,
        S_PUSH_LO,
        S_PUSH_P,
        S_PULL_P,
        S_PULL_LO,
        S_PULL_HI,
        S_VEC_LO,
        S_VEC_HI,
        S_FINISH
    } sis_state_e;

    typedef enum logic [2:0] {
        K_ENTRY,
        K_RESET,
        K_CALL,
        K_RETSUB,
        K_RETINT,
        K_PUSHP,
        K_PULLP
    } sis_kind_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_MASKABLE,
        PEND_NMI
    } sis_pend_e;

    localparam logic [7:0]  STACK_PAGE   = 8'h01;
    localparam logic [7:0]  SP_AT_RESET  = 8'hFD;
    localparam logic [7:0]  P_AT_RESET   = 8'h24;
    localparam logic [7:0]  P_BREAK_BIT  = 8'h10;
    localparam logic [7:0]  P_UNUSED_BIT = 8'h20;
    localparam logic [7:0]  P_MASK_BIT   = 8'h04;
    localparam int          P_MASK_POS   = 2;

    localparam logic [15:0] VEC_NMI      = 16'hFFFA;
    localparam logic [15:0] VEC_RESET    = 16'hFFFC;
    localparam logic [15:0] VEC_MASKABLE = 16'hFFFE;

    localparam int COST_ENTRY = 7;
    localparam int COST_RESET = 7;
    localparam int COST_STALL = 1;
    localparam int COST_CALL  = 6;
    localparam int COST_RET   = 6;
    localparam int COST_PUSHP = 3;
    localparam int COST_PULLP = 4;

endpackage

// File: rtl/sis_stall.sv
module sis_stall #(
    parameter int STALL_W = 16,
    parameter int ADD_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_valid,
    input  logic [ADD_W-1:0] add_amt,
    input  logic             dec,
    output logic             nonzero
);
    localparam int          SUM_W   = STALL_W + 1;
    localparam logic [SUM_W-1:0] CNT_MAX = {1'b0, {STALL_W{1'b1}}};

    logic [STALL_W-1:0] cnt_q, cnt_d;
    logic [SUM_W-1:0]   sum;

    always_comb begin
        sum = {1'b0, cnt_q}
            + (add_valid ? SUM_W'(add_amt) : '0)
            - SUM_W'(dec);
        cnt_d = (sum > CNT_MAX) ? CNT_MAX[STALL_W-1:0] : sum[STALL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/sis_irq_slot.sv
module sis_irq_slot
    import sis_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      nmi_req,
    input  logic      irq_req,
    input  logic      take,
    output sis_pend_e pend
);
    sis_pend_e pend_q, pend_d, base;

    always_comb begin
        base = take ? PEND_NONE : pend_q;
        if (nmi_req)
            pend_d = PEND_NMI;
        else if (irq_req && base != PEND_NMI)
            pend_d = PEND_MASKABLE;
        else
            pend_d = base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= PEND_NONE;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
endmodule

// File: rtl/stack_irq_seq.sv
module stack_irq_seq
    import sis_pkg::*;
#(
    parameter int STALL_W = 16,
    parameter int ADD_W   = 8,
    parameter int CYC_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [15:0]      pc_in,
    input  logic [15:0]      target_in,
    input  logic [7:0]       status_in,
    input  logic             nmi_req,
    input  logic             irq_req,
    input  logic             stall_add_valid,
    input  logic [ADD_W-1:0] stall_add_amt,
    output logic [15:0]      mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             mem_we,
    output logic             mem_re,
    input  logic [7:0]       mem_rdata,
    output logic             busy,
    output logic             done,
    output logic             issue_ok,
    output logic [CYC_W-1:0] cycles_out,
    output logic [15:0]      pc_out,
    output logic [7:0]       status_out,
    output logic [7:0]       sp_out
);
    typedef struct packed {
        sis_state_e       st;
        sis_kind_e        kind;
        logic [7:0]       sp;
        logic [15:0]      word;
        logic [15:0]      pc;
        logic [7:0]       p;
        logic [7:0]       push_p;
        logic [15:0]      vec;
        logic [CYC_W-1:0] cyc;
        logic             issue;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        st: S_IDLE, kind: K_RESET, sp: SP_AT_RESET, word: 16'h0000,
        pc: 16'h0000, p: P_AT_RESET, push_p: 8'h00, vec: VEC_RESET,
        cyc: '0, issue: 1'b0
    };

    seq_t      r_q, r_d;
    logic      stall_nz, stall_dec, take;
    sis_pend_e pend;
    logic [7:0] sp_inc;
    logic [7:0] pulled_p;

    assign sp_inc   = r_q.sp + 8'd1;
    assign pulled_p = (mem_rdata & ~P_BREAK_BIT) | P_UNUSED_BIT;

    sis_stall #(
        .STALL_W (STALL_W),
        .ADD_W   (ADD_W)
    ) stall_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_valid (stall_add_valid),
        .add_amt   (stall_add_amt),
        .dec       (stall_dec),
        .nonzero   (stall_nz)
    );

    sis_irq_slot slot_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_req (nmi_req),
        .irq_req (irq_req),
        .take    (take),
        .pend    (pend)
    );

    always_comb begin
        r_d       = r_q;
        mem_addr  = 16'h0000;
        mem_wdata = 8'h00;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        stall_dec = 1'b0;
        take      = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    r_d.pc    = pc_in;
                    r_d.p     = status_in;
                    r_d.issue = 1'b0;
                    case (cmd_op)
                        OP_STEP: begin
                            r_d.issue = 1'b1;
                            if (stall_nz) begin
                                stall_dec = 1'b1;
                                r_d.issue = 1'b0;
                                r_d.cyc   = CYC_W'(COST_STALL);
                                r_d.st    = S_FINISH;
                            end else if (pend == PEND_NMI ||
                                         (pend == PEND_MASKABLE && !status_in[P_MASK_POS])) begin
                                take       = 1'b1;
                                r_d.kind   = K_ENTRY;
                                r_d.word   = pc_in;
                                r_d.push_p = status_in | P_BREAK_BIT;
                                r_d.p      = status_in | P_MASK_BIT;
                                r_d.vec    = (pend == PEND_NMI) ? VEC_NMI : VEC_MASKABLE;
                                r_d.cyc    = CYC_W'(COST_ENTRY);
                                r_d.st     = S_PUSH_HI;
                            end else begin
                                r_d.cyc = '0;
                                r_d.st  = S_FINISH;
                            end
                        end
                        OP_RESET: begin
                            r_d.kind = K_RESET;
                            r_d.sp   = SP_AT_RESET;
                            r_d.p    = P_AT_RESET;
                            r_d.vec  = VEC_RESET;
                            r_d.cyc  = CYC_W'(COST_RESET);
                            r_d.st   = S_VEC_LO;
                        end
                        OP_BRK: begin
                            r_d.kind   = K_ENTRY;
                            r_d.word   = pc_in;
                            r_d.push_p = status_in | P_BREAK_BIT;
                            r_d.p      = status_in | P_MASK_BIT;
                            r_d.vec    = VEC_MASKABLE;
                            r_d.cyc    = CYC_W'(COST_ENTRY);
                            r_d.st     = S_PUSH_HI;
                        end
                        OP_JSR: begin
                            r_d.kind = K_CALL;
                            r_d.word = pc_in - 16'd1;
                            r_d.pc   = target_in;
                            r_d.cyc  = CYC_W'(COST_CALL);
                            r_d.st   = S_PUSH_HI;
                        end
                        OP_RTS: begin
                            r_d.kind = K_RETSUB;
                            r_d.cyc  = CYC_W'(COST_RET);
                            r_d.st   = S_PULL_LO;
                        end
                        OP_RTI: begin
                            r_d.kind = K_RETINT;
                            r_d.cyc  = CYC_W'(COST_RET);
                            r_d.st   = S_PULL_P;
                        end
                        OP_PHP: begin
                            r_d.kind   = K_PUSHP;
                            r_d.push_p = status_in | P_BREAK_BIT;
                            r_d.cyc    = CYC_W'(COST_PUSHP);
                            r_d.st     = S_PUSH_P;
                        end
                        OP_PLP: begin
                            r_d.kind = K_PULLP;
                            r_d.cyc  = CYC_W'(COST_PULLP);
                            r_d.st   = S_PULL_P;
                        end
                        default: r_d = r_q;
                    endcase
                end
            end
            S_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, r_q.sp};
                mem_wdata = r_q.word[15:8];
                r_d.sp    = r_q.sp - 8'd1;
                r_d.st    = S_PUSH_LO;
            end
            S_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, r_q.sp};
                mem_wdata = r_q.word[7:0];
                r_d.sp    = r_q.sp - 8'd1;
                r_d.st    = (r_q.kind == K_ENTRY) ? S_PUSH_P : S_FINISH;
            end
            S_PUSH_P: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, r_q.sp};
                mem_wdata = r_q.push_p;
                r_d.sp    = r_q.sp - 8'd1;
                r_d.st    = (r_q.kind == K_ENTRY) ? S_VEC_LO : S_FINISH;
            end
            S_PULL_P: begin
                mem_re   = 1'b1;
                mem_addr = {STACK_PAGE, sp_inc};
                r_d.sp   = sp_inc;
                r_d.p    = pulled_p;
                r_d.st   = (r_q.kind == K_RETINT) ? S_PULL_LO : S_FINISH;
            end
            S_PULL_LO: begin
                mem_re       = 1'b1;
                mem_addr     = {STACK_PAGE, sp_inc};
                r_d.sp       = sp_inc;
                r_d.pc[7:0]  = mem_rdata;
                r_d.st       = S_PULL_HI;
            end
            S_PULL_HI: begin
                mem_re   = 1'b1;
                mem_addr = {STACK_PAGE, sp_inc};
                r_d.sp   = sp_inc;
                if (r_q.kind == K_RETSUB)
                    r_d.pc = {mem_rdata, r_q.pc[7:0]} + 16'd1;
                else
                    r_d.pc = {mem_rdata, r_q.pc[7:0]};
                r_d.st   = S_FINISH;
            end
            S_VEC_LO: begin
                mem_re      = 1'b1;
                mem_addr    = r_q.vec;
                r_d.pc[7:0] = mem_rdata;
                r_d.st      = S_VEC_HI;
            end
            S_VEC_HI: begin
                mem_re       = 1'b1;
                mem_addr     = r_q.vec + 16'd1;
                r_d.pc[15:8] = mem_rdata;
                r_d.st       = S_FINISH;
            end
            S_FINISH: begin
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SEQ_RESET;
        else        r_q <= r_d;
    end

    assign busy       = (r_q.st != S_IDLE);
    assign done       = (r_q.st == S_FINISH);
    assign issue_ok   = done && r_q.issue;
    assign cycles_out = r_q.cyc;
    assign pc_out     = r_q.pc;
    assign status_out = r_q.p;
    assign sp_out     = r_q.sp;
endmodule

// File: rtl/sis_checker.sv
module sis_checker
    import sis_pkg::*;
#(
    parameter int CYC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_we,
    input logic             mem_re,
    input logic [15:0]      mem_addr,
    input logic [7:0]       sp_out,
    input logic [7:0]       status_out,
    input logic             done,
    input logic             issue_ok,
    input logic [CYC_W-1:0] cycles_out
);
    AST_PUSH_IN_PAGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[15:8] == STACK_PAGE) else $error("push outside stack page"); // R1

    AST_PUSH_THEN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_out == $past(mem_addr[7:0]) - 8'd1) else $error("sp not decremented after push"); // R1

    AST_PULL_AT_NEW_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && mem_addr[15:8] == STACK_PAGE) |=> sp_out == $past(mem_addr[7:0])) else $error("pull address not incremented sp"); // R1

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)) else $error("read and write together"); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R12

    AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cycles_out == CYC_W'(COST_ENTRY)) |-> status_out[P_MASK_POS]) else $error("entry left mask clear"); // R3

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !issue_ok && cycles_out == CYC_W'(COST_STALL)) |-> $past(!mem_we && !mem_re)) else $error("stall step touched memory"); // R8
endmodule

bind stack_irq_seq sis_checker #(.CYC_W(CYC_W)) chk_i (.*);

// File: tb/stack_irq_seq_tb.sv
module stack_irq_seq_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [15:0] pc_in = 16'h0, target_in = 16'h0;
    logic [7:0]  status_in = 8'h0;
    logic        nmi_req = 1'b0, irq_req = 1'b0;
    logic        stall_add_valid = 1'b0;
    logic [7:0]  stall_add_amt = 8'h0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_we, mem_re, busy, done, issue_ok;
    logic [3:0]  cycles_out;
    logic [15:0] pc_out;
    logic [7:0]  status_out, sp_out;

    int nchk = 0;
    int nerr = 0;

    logic [7:0]  page1 [256];
    logic [15:0] wa [64];
    logic [7:0]  wd [64];
    logic [15:0] ra [64];
    int wn = 0;
    int rn = 0;

    always #2.5 clk = ~clk;

    stack_irq_seq dut_i (.*);

    function automatic logic [7:0] rd_byte(input logic [15:0] a);
        if (a[15:8] == 8'h01) return page1[a[7:0]];
        case (a)
            16'hFFFA: return 8'h34;
            16'hFFFB: return 8'h12;
            16'hFFFC: return 8'h00;
            16'hFFFD: return 8'h80;
            16'hFFFE: return 8'h78;
            16'hFFFF: return 8'h56;
            default:  return 8'h00;
        endcase
    endfunction

    assign mem_rdata = rd_byte(mem_addr);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) page1[i] <= 8'h00;
        end else begin
            if (mem_we) begin
                if (mem_addr[15:8] == 8'h01) page1[mem_addr[7:0]] <= mem_wdata;
                wa[wn[5:0]] <= mem_addr;
                wd[wn[5:0]] <= mem_wdata;
                wn <= wn + 1;
            end
            if (mem_re) begin
                ra[rn[5:0]] <= mem_addr;
                rn <= rn + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [15:0] pc, input logic [15:0] tgt,
                       input logic [7:0] st, output int lat);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; pc_in = pc; target_in = tgt; status_in = st;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic pulse_req(input logic n, input logic i);
        @(negedge clk); nmi_req = n; irq_req = i;
        @(negedge clk); nmi_req = 1'b0; irq_req = 1'b0;
    endtask

    task automatic add_stall(input logic [7:0] amt);
        @(negedge clk); stall_add_valid = 1'b1; stall_add_amt = amt;
        @(negedge clk); stall_add_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R2", "sp after rst_n", sp_out, 8'hFD);
        chk("R2", "status after rst_n", status_out, 8'h24);
        chk("R12", "busy after rst_n", busy, 1'b0);
        chk("R12", "done after rst_n", done, 1'b0);
    endtask

    task automatic t_reset_cmd();
        int lat; int r0 = rn;
        run(4'd2, 16'h0, 16'h0, 8'hFF, lat);
        chk("R12", "reset latency", lat, 3);
        chk("R2", "reset read 0", ra[r0[5:0]], 16'hFFFC);
        chk("R2", "reset read 1", ra[(r0 + 1) % 64], 16'hFFFD);
        chk("R2", "reset pc", pc_out, 16'h8000);
        chk("R2", "reset sp", sp_out, 8'hFD);
        chk("R2", "reset status", status_out, 8'h24);
        chk("R2", "reset cycles", cycles_out, 7);
    endtask

    task automatic t_call_return();
        int lat; int w0 = wn; int r0;
        run(4'd4, 16'h8003, 16'h9000, 8'h24, lat);
        chk("R11", "jsr latency", lat, 3);
        chk("R11", "jsr hi addr", wa[w0[5:0]], 16'h01FD);
        chk("R11", "jsr hi data", wd[w0[5:0]], 8'h80);
        chk("R11", "jsr lo addr", wa[(w0 + 1) % 64], 16'h01FC);
        chk("R11", "jsr lo data", wd[(w0 + 1) % 64], 8'h02);
        chk("R11", "jsr pc", pc_out, 16'h9000);
        chk("R11", "jsr sp", sp_out, 8'hFB);
        chk("R11", "jsr cycles", cycles_out, 6);
        r0 = rn;
        run(4'd5, 16'h9010, 16'h0, 8'h24, lat);
        chk("R11", "rts latency", lat, 3);
        chk("R11", "rts first read", ra[r0[5:0]], 16'h01FC);
        chk("R11", "rts second read", ra[(r0 + 1) % 64], 16'h01FD);
        chk("R11", "rts pc", pc_out, 16'h8003);
        chk("R11", "rts sp", sp_out, 8'hFD);
    endtask

    task automatic t_status_push_pull();
        int lat; int w0 = wn;
        run(4'd7, 16'h8100, 16'h0, 8'hC3, lat);
        chk("R9", "php latency", lat, 2);
        chk("R9", "php addr", wa[w0[5:0]], 16'h01FD);
        chk("R9", "php data", wd[w0[5:0]], 8'hD3);
        chk("R9", "php cycles", cycles_out, 3);
        chk("R9", "php sp", sp_out, 8'hFC);
        run(4'd8, 16'h8100, 16'h0, 8'h00, lat);
        chk("R9", "plp latency", lat, 2);
        chk("R9", "plp status", status_out, 8'hE3);
        chk("R9", "plp cycles", cycles_out, 4);
        chk("R9", "plp sp", sp_out, 8'hFD);
    endtask

    task automatic t_nmi_and_rti();
        int lat; int w0; int r0;
        pulse_req(1'b1, 1'b0);
        w0 = wn;
        run(4'd1, 16'h8123, 16'h0, 8'h20, lat);
        chk("R3", "nmi latency", lat, 6);
        chk("R3", "nmi push hi", {wa[w0[5:0]], wd[w0[5:0]]}, {16'h01FD, 8'h81});
        chk("R3", "nmi push lo", {wa[(w0 + 1) % 64], wd[(w0 + 1) % 64]}, {16'h01FC, 8'h23});
        chk("R3", "nmi push status", {wa[(w0 + 2) % 64], wd[(w0 + 2) % 64]}, {16'h01FB, 8'h30});
        chk("R3", "nmi pc", pc_out, 16'h1234);
        chk("R3", "nmi status", status_out, 8'h24);
        chk("R3", "nmi cycles", cycles_out, 7);
        chk("R3", "nmi issue", issue_ok, 1'b1);
        run(4'd1, 16'h1234, 16'h0, 8'h24, lat);
        chk("R5", "slot cleared latency", lat, 1);
        chk("R5", "slot cleared cycles", cycles_out, 0);
        chk("R5", "slot cleared issue", issue_ok, 1'b1);
        chk("R5", "slot cleared sp", sp_out, 8'hFA);
        r0 = rn;
        run(4'd6, 16'h1300, 16'h0, 8'h24, lat);
        chk("R10", "rti latency", lat, 4);
        chk("R10", "rti read order", {ra[r0[5:0]], ra[(r0 + 1) % 64], ra[(r0 + 2) % 64]},
            {16'h01FB, 16'h01FC, 16'h01FD});
        chk("R10", "rti status", status_out, 8'h20);
        chk("R10", "rti pc", pc_out, 16'h8123);
        chk("R10", "rti cycles", cycles_out, 6);
    endtask

    task automatic t_brk();
        int lat; int w0 = wn; int r0 = rn;
        run(4'd3, 16'h8200, 16'h0, 8'h01, lat);
        chk("R4", "brk latency", lat, 6);
        chk("R4", "brk pushes", {wd[w0[5:0]], wd[(w0 + 1) % 64], wd[(w0 + 2) % 64]}, {8'h82, 8'h00, 8'h11});
        chk("R4", "brk vector read", ra[r0[5:0]], 16'hFFFE);
        chk("R4", "brk pc", pc_out, 16'h5678);
        chk("R4", "brk status", status_out, 8'h05);
        chk("R4", "brk sp", sp_out, 8'hFA);
    endtask

    task automatic t_masked_irq();
        int lat; int w0;
        pulse_req(1'b0, 1'b1);
        w0 = wn;
        run(4'd1, 16'h8300, 16'h0, 8'h24, lat);
        chk("R7", "masked latency", lat, 1);
        chk("R7", "masked no push", wn - w0, 0);
        chk("R7", "masked cycles", cycles_out, 0);
        run(4'd1, 16'h8300, 16'h0, 8'h20, lat);
        chk("R7", "unmasked latency", lat, 6);
        chk("R7", "unmasked pc", pc_out, 16'h5678);
        chk("R4", "irq status", status_out, 8'h24);
    endtask

    task automatic t_priority();
        int lat;
        pulse_req(1'b1, 1'b1);
        run(4'd1, 16'h8400, 16'h0, 8'h20, lat);
        chk("R6", "nmi wins pc", pc_out, 16'h1234);
        run(4'd1, 16'h1234, 16'h0, 8'h20, lat);
        chk("R6", "irq lost latency", lat, 1);
        chk("R6", "irq lost cycles", cycles_out, 0);
    endtask

    task automatic t_stall();
        int lat; int w0; int r0;
        add_stall(8'd2);
        add_stall(8'd1);
        pulse_req(1'b1, 1'b0);
        w0 = wn; r0 = rn;
        for (int k = 0; k < 3; k++) begin
            run(4'd1, 16'h8500, 16'h0, 8'h20, lat);
            chk("R8", "stall latency", lat, 1);
            chk("R8", "stall cycles", cycles_out, 1);
            chk("R8", "stall no issue", issue_ok, 1'b0);
        end
        chk("R8", "stall no traffic", (wn - w0) + (rn - r0), 0);
        run(4'd1, 16'h8500, 16'h0, 8'h20, lat);
        chk("R8", "after stall entry pc", pc_out, 16'h1234);
        chk("R8", "after stall entry cycles", cycles_out, 7);
    endtask

    task automatic t_busy_ignore();
        int w0 = wn;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'd7; status_in = 8'h00;
        @(negedge clk);
        chk("R12", "busy during php", busy, 1'b1);
        cmd_op = 4'd8;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R12", "php done at edge 2", done, 1'b1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R12", "no second done", done, 1'b0);
        end
        chk("R12", "one push only", wn - w0, 1);
        chk("R12", "sp after ignored cmd", sp_out, 8'hFC);
    endtask

    task automatic t_wrap();
        int lat; int w0; int r0;
        run(4'd8, 16'h0, 16'h0, 8'h00, lat);
        run(4'd8, 16'h0, 16'h0, 8'h00, lat);
        chk("R1", "sp at ff", sp_out, 8'hFF);
        r0 = rn;
        run(4'd8, 16'h0, 16'h0, 8'h00, lat);
        chk("R1", "wrap pull addr", ra[r0[5:0]], 16'h0100);
        chk("R1", "wrap pull sp", sp_out, 8'h00);
        w0 = wn;
        run(4'd7, 16'h0, 16'h0, 8'h00, lat);
        chk("R1", "wrap push addr", wa[w0[5:0]], 16'h0100);
        chk("R1", "wrap push data", wd[w0[5:0]], 8'h10);
        chk("R1", "wrap push sp", sp_out, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_reset_cmd();
        t_call_return();
        t_status_push_pull();
        t_nmi_and_rti();
        t_brk();
        t_reset_cmd();
        t_masked_irq();
        t_reset_cmd();
        t_priority();
        t_reset_cmd();
        t_stall();
        t_reset_cmd();
        t_busy_ignore();
        t_reset_cmd();
        t_wrap();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule